// File: doc/BRIEF.md
# Exclusive Last-Level Cache Eviction Router

This block sits beside a private second-level cache controller in a hierarchy whose last-level cache (LLC) holds blocks exclusively. For every block leaving the second-level cache it picks one destination: allocate the block in the LLC, update a copy already resident in the LLC, write it back to the memory controller, or drop it in the controller so that it never reaches the interconnect. The inputs to that choice are a liveness verdict supplied by a separate predictor, the block's dirty state, a flag marking blocks that have hit in the LLC before (reuse class 4), and a flag saying whether the target LLC set has a free way.

The block also tells the LLC what to do with a block it returns on a hit: deallocate it, or keep it resident. It also routes demand misses so that the fill goes to the second-level cache straight from memory. A mode input selects plain strict exclusion or a flexible variant. In the flexible variant, class-4 blocks are cached non-inclusively: they stay in the LLC on a hit, clean ones are dropped on eviction, and dirty ones refresh the resident copy. Four saturating counters record allocations, updates, writebacks and drops, so the fraction of evictions kept off the LLC can be measured.

Top module: `evict_router`

## Requirements
- R1: While reset (rstN low) is asserted and in the first cycle after it, evictDone, hitDone, hitKeep and missFillMem are 0 and all four counters are 0.
- R2: An eviction with evictLive=1 and c4Mode=0 gives evictDone=1 with evictAction=0 (allocate) one clock later, whatever the dirty, class-4 and free-way flags are.
- R3: A dead eviction (evictLive=0) whose target set has a free way (setHasFree=1) gives evictAction=0 (allocate) in both modes.
- R4: A dead dirty eviction with setHasFree=0 gives evictAction=2 (write back to memory).
- R5: A dead clean eviction with setHasFree=0 gives evictAction=3 (drop, no interconnect traffic).
- R6: With c4Mode=1, a live eviction with evictC4=0 gives evictAction=0 (allocate).
- R7: With c4Mode=1, a live eviction with evictC4=1 gives evictAction=1 (update the resident copy) when dirty and evictAction=3 (drop) when clean, even if the set has a free way.
- R8: A hit (hitValid=1) gives hitDone=1 one clock later. hitKeep=1 (keep resident) only when c4Mode=1 and hitC4=1. Otherwise hitKeep=0 (deallocate).
- R9: A miss (missValid=1) gives missFillMem=1 one clock later and changes no counter.
- R10: allocCount, updateCount, writebackCount and dropCount each rise by one for every eviction given action 0, 1, 2 and 3 respectively, and hold at all ones once they reach it.
- R11: A cycle without evictValid gives evictDone=0 one clock later and leaves every counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| c4Mode | input | 1 | 1 selects flexible exclusion for class-4 blocks |
| evictValid | input | 1 | An eviction is presented this cycle |
| evictLive | input | 1 | Predictor verdict: block is live |
| evictDirty | input | 1 | Evicted block is dirty |
| evictC4 | input | 1 | Evicted block belongs to reuse class 4 |
| setHasFree | input | 1 | Target LLC set has a free way |
| hitValid | input | 1 | LLC hit response to steer |
| hitC4 | input | 1 | The hit block is class 4 |
| missValid | input | 1 | LLC miss needing a memory fill |
| evictDone | output | 1 | Eviction decision valid |
| evictAction | output | 2 | 0 allocate, 1 update resident, 2 memory writeback, 3 drop |
| hitDone | output | 1 | Hit response valid |
| hitKeep | output | 1 | 1 keep block in LLC, 0 deallocate |
| missFillMem | output | 1 | Fill goes to the L2 from memory, bypassing the LLC |
| allocCount | output | CNT_W | Allocations |
| updateCount | output | CNT_W | In-place updates |
| writebackCount | output | CNT_W | Memory writebacks |
| dropCount | output | CNT_W | Drops |

## Verification
The bench builds the router with CNT_W=3, so each counter tops out at 7. A short run can therefore drive the drop counter into saturation and confirm that it holds there while further drops arrive. A table walks every routing case in both modes. Directed tests then cover the hit response, the miss path and idle cycles, and check the counters against a model kept by the bench.

// File: rtl/evrt_pkg.sv
package evrt_pkg;
  typedef enum logic [1:0] {
    ACT_ALLOC  = 2'd0,
    ACT_UPDATE = 2'd1,
    ACT_MEMWB  = 2'd2,
    ACT_DROP   = 2'd3
  } evictAct_e;

  localparam int unsigned NUM_ACTS = 4;

  typedef struct packed {
    logic alloc;
    logic update;
    logic memWb;
    logic drop;
    logic hitKeep;
    logic hitFree;
    logic missMem;
  } routeStrobe_t;
endpackage

// File: rtl/evrt_satcnt.sv
module evrt_satcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN)                     cnt <= '0;
    else if (inc && cnt != MAXV)   cnt <= cnt + 1'b1;
  end

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == MAXV) |=> (cnt == MAXV));
  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inc && cnt != MAXV) |=> (cnt == $past(cnt) + 1'b1));
  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/evrt_ctrl.sv
module evrt_ctrl
  import evrt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         c4Mode,
  input  logic         evictValid,
  input  logic         evictLive,
  input  logic         evictDirty,
  input  logic         evictC4,
  input  logic         setHasFree,
  input  logic         hitValid,
  input  logic         hitC4,
  input  logic         missValid,
  output routeStrobe_t strb
);
  logic flexClass;
  assign flexClass = c4Mode && evictLive && evictC4;

  always_comb begin
    strb = '0;
    if (evictValid) begin
      if (flexClass) begin
        if (evictDirty) strb.update = 1'b1;
        else            strb.drop   = 1'b1;
      end else if (evictLive || setHasFree) begin
        strb.alloc = 1'b1;
      end else if (evictDirty) begin
        strb.memWb = 1'b1;
      end else begin
        strb.drop = 1'b1;
      end
    end
    if (hitValid) begin
      if (c4Mode && hitC4) strb.hitKeep = 1'b1;
      else                 strb.hitFree = 1'b1;
    end
    strb.missMem = missValid;
  end

  // R10
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.alloc, strb.update, strb.memWb, strb.drop}));
  // R8
  hit_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.hitKeep && strb.hitFree));
endmodule

// File: rtl/evrt_datapath.sv
module evrt_datapath
  import evrt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  routeStrobe_t     strb,
  output logic             evictDone,
  output logic [1:0]       evictAction,
  output logic             hitDone,
  output logic             hitKeep,
  output logic             missFillMem,
  output logic [CNT_W-1:0] allocCount,
  output logic [CNT_W-1:0] updateCount,
  output logic [CNT_W-1:0] writebackCount,
  output logic [CNT_W-1:0] dropCount
);
  logic [NUM_ACTS-1:0] incVec;
  logic [CNT_W-1:0]    cntArr [NUM_ACTS];
  evictAct_e           nextAct;

  assign incVec = {strb.drop, strb.memWb, strb.update, strb.alloc};

  always_comb begin
    nextAct = ACT_ALLOC;
    if (strb.update)     nextAct = ACT_UPDATE;
    else if (strb.memWb) nextAct = ACT_MEMWB;
    else if (strb.drop)  nextAct = ACT_DROP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evictDone   <= 1'b0;
      evictAction <= 2'd0;
      hitDone     <= 1'b0;
      hitKeep     <= 1'b0;
      missFillMem <= 1'b0;
    end else begin
      evictDone   <= |incVec;
      evictAction <= nextAct;
      hitDone     <= strb.hitKeep | strb.hitFree;
      hitKeep     <= strb.hitKeep;
      missFillMem <= strb.missMem;
    end
  end

  for (genvar gi = 0; gi < NUM_ACTS; gi++) begin : g_cnt
    evrt_satcnt #(.W(CNT_W)) cnt_i (
      .clk  (clk),
      .rstN (rstN),
      .inc  (incVec[gi]),
      .cnt  (cntArr[gi])
    );
  end

  assign allocCount     = cntArr[ACT_ALLOC];
  assign updateCount    = cntArr[ACT_UPDATE];
  assign writebackCount = cntArr[ACT_MEMWB];
  assign dropCount      = cntArr[ACT_DROP];

  // R9
  miss_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.missMem && incVec == '0) |=> ($stable(allocCount) && $stable(dropCount)));
endmodule

// File: rtl/evict_router.sv
module evict_router #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             c4Mode,
  input  logic             evictValid,
  input  logic             evictLive,
  input  logic             evictDirty,
  input  logic             evictC4,
  input  logic             setHasFree,
  input  logic             hitValid,
  input  logic             hitC4,
  input  logic             missValid,
  output logic             evictDone,
  output logic [1:0]       evictAction,
  output logic             hitDone,
  output logic             hitKeep,
  output logic             missFillMem,
  output logic [CNT_W-1:0] allocCount,
  output logic [CNT_W-1:0] updateCount,
  output logic [CNT_W-1:0] writebackCount,
  output logic [CNT_W-1:0] dropCount
);
  evrt_pkg::routeStrobe_t strb;

  evrt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .c4Mode(c4Mode), .evictValid(evictValid),
    .evictLive(evictLive), .evictDirty(evictDirty), .evictC4(evictC4),
    .setHasFree(setHasFree), .hitValid(hitValid), .hitC4(hitC4),
    .missValid(missValid), .strb(strb)
  );

  evrt_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .evictDone(evictDone), .evictAction(evictAction),
    .hitDone(hitDone), .hitKeep(hitKeep), .missFillMem(missFillMem),
    .allocCount(allocCount), .updateCount(updateCount),
    .writebackCount(writebackCount), .dropCount(dropCount)
  );

  // R2
  live_plain_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evictValid && evictLive && !c4Mode) |=> (evictDone && evictAction == 2'd0));
  // R3
  dead_free_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evictValid && !evictLive && setHasFree) |=> (evictDone && evictAction == 2'd0));
  // R4
  dead_dirty_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evictValid && !evictLive && evictDirty && !setHasFree) |=> (evictAction == 2'd2));
  // R5
  dead_clean_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evictValid && !evictLive && !evictDirty && !setHasFree) |=> (evictAction == 2'd3));
  // R7
  flex_c4_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evictValid && c4Mode && evictLive && evictC4) |=> (evictAction[0] && evictDone));
  // R8
  hit_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |=> (hitDone && hitKeep == $past(c4Mode && hitC4)));
  // R9
  miss_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    missValid |=> missFillMem);
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evictValid |=> !evictDone);
endmodule

// File: tb/evict_router_tb_top.sv
module evict_router_tb_top;
  localparam int unsigned CNT_W = 3;
  localparam int unsigned NVEC  = 13;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // {mode, live, dirty, c4, free, expAct[1:0]}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_1_0_0_0_00, // R2 live clean
    7'b0_1_1_1_0_00, // R2 live dirty c4, plain mode ignores class
    7'b0_0_0_0_1_00, // R3 dead with free way
    7'b0_0_1_0_0_10, // R4 dead dirty
    7'b0_0_0_0_0_11, // R5 dead clean
    7'b0_0_0_1_0_11, // R5 dead clean c4
    7'b1_1_0_0_0_00, // R6 live non-c4
    7'b1_1_1_0_1_00, // R6 live non-c4 dirty
    7'b1_1_1_1_0_01, // R7 live c4 dirty -> update
    7'b1_1_0_1_1_11, // R7 live c4 clean -> drop
    7'b1_0_1_0_1_00, // R3 dead, free way, flex mode
    7'b1_0_1_1_0_10, // R4 dead dirty flex mode
    7'b1_0_0_0_0_11  // R5 dead clean flex mode
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic c4Mode = 0, evictValid = 0, evictLive = 0, evictDirty = 0, evictC4 = 0;
  logic setHasFree = 0, hitValid = 0, hitC4 = 0, missValid = 0;
  logic evictDone, hitDone, hitKeep, missFillMem;
  logic [1:0] evictAction;
  logic [CNT_W-1:0] allocCount, updateCount, writebackCount, dropCount;

  int checks = 0, failures = 0;
  bit finished = 0;
  int expCnt [4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  evict_router #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .c4Mode(c4Mode), .evictValid(evictValid),
    .evictLive(evictLive), .evictDirty(evictDirty), .evictC4(evictC4),
    .setHasFree(setHasFree), .hitValid(hitValid), .hitC4(hitC4),
    .missValid(missValid), .evictDone(evictDone), .evictAction(evictAction),
    .hitDone(hitDone), .hitKeep(hitKeep), .missFillMem(missFillMem),
    .allocCount(allocCount), .updateCount(updateCount),
    .writebackCount(writebackCount), .dropCount(dropCount)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkCounts(input string tag);
    chk({tag, " allocCount R10"}, allocCount, expCnt[0]);
    chk({tag, " updateCount R10"}, updateCount, expCnt[1]);
    chk({tag, " writebackCount R10"}, writebackCount, expCnt[2]);
    chk({tag, " dropCount R10"}, dropCount, expCnt[3]);
  endtask

  function automatic string reqOf(input logic [6:0] v);
    if (!v[6] && v[5])     return "R2";
    if (!v[5] && v[2])     return "R3";
    if (!v[5] && v[4])     return "R4";
    if (!v[5])             return "R5";
    if (!v[3])             return "R6";
    return "R7";
  endfunction

  task automatic evict(input logic m, input logic l, input logic d,
                       input logic c, input logic f, input int expAct,
                       input string tag);
    @(negedge clk);
    c4Mode = m; evictLive = l; evictDirty = d; evictC4 = c; setHasFree = f;
    evictValid = 1'b1;
    @(negedge clk);
    evictValid = 1'b0;
    if (expCnt[expAct] < int'(CMAX)) expCnt[expAct]++;
    chk({tag, " evictDone"}, evictDone, 1);
    chk({tag, " evictAction"}, evictAction, expAct);
  endtask

  task automatic hit(input logic m, input logic c, input int expKeep, input string tag);
    @(negedge clk);
    c4Mode = m; hitC4 = c; hitValid = 1'b1;
    @(negedge clk);
    hitValid = 1'b0;
    chk({tag, " hitDone"}, hitDone, 1);
    chk({tag, " hitKeep"}, hitKeep, expKeep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 evictDone", evictDone, 0);
    chk("R1 hitDone", hitDone, 0);
    chk("R1 missFillMem", missFillMem, 0);
    chkCounts("R1");
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 hitKeep after reset", hitKeep, 0);

    for (int i = 0; i < NVEC; i++) begin
      evict(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2],
            int'(VEC[i][1:0]), reqOf(VEC[i]));
      chkCounts(reqOf(VEC[i]));
    end

    // R8 hit responses
    hit(1'b0, 1'b1, 0, "R8 plain c4 hit deallocates");
    hit(1'b1, 1'b1, 1, "R8 flex c4 hit kept");
    hit(1'b1, 1'b0, 0, "R8 flex non-c4 hit deallocates");

    // R9 miss fill from memory, counters untouched
    @(negedge clk);
    missValid = 1'b1;
    @(negedge clk);
    missValid = 1'b0;
    chk("R9 missFillMem", missFillMem, 1);
    chk("R9 evictDone", evictDone, 0);
    chkCounts("R9");

    // R11 idle cycle with flags set but no valid
    @(negedge clk);
    c4Mode = 1; evictLive = 1; evictDirty = 1; evictC4 = 1; setHasFree = 1;
    @(negedge clk);
    chk("R11 evictDone idle", evictDone, 0);
    chkCounts("R11");

    // R10 drive drop counter to saturation and beyond
    for (int k = 0; k < 6; k++) begin
      evict(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3, "R10 drop sat");
    end
    chk("R10 dropCount saturated", dropCount, int'(CMAX));
    chkCounts("R10 final");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule